// File: doc/BRIEF.md
# Binary64 to Int32 Converter with Selectable Rounding

This unit turns an IEEE-754 double-precision operand into a signed 32-bit integer. The rounding rule is not fixed per operation. It comes from a 2-bit mode input, which the surrounding pipeline drives from the rounding field of its floating-point control/status register. One conversion is accepted per clock whenever the input strobe is high. The result and two status flags appear registered on the following cycle.

A result that needed rounding raises the inexact flag. Some operands have no representable answer: a NaN, an infinity, or a value that rounds outside the 32-bit signed range. For these the unit returns the fixed code 0x7FFFFFFF and raises the invalid flag. The flags are mutually exclusive, so an invalid conversion never also reports inexact. Between strobes the result and flags keep their last values.

Top module: `d2i_convert`

## Requirements
- R1: `outValid` is high in exactly the cycles that follow a cycle with `inValid` high, and the `result`, `inexact` and `invalid` of that conversion appear in that same cycle.
- R2: Mode code 0 rounds to the nearest integer, and an exact tie goes to the even neighbour (2.5 gives 2, 3.5 gives 4, -2.5 gives -2).
- R3: Mode code 1 rounds toward zero (1.9 gives 1, -1.9 gives -1).
- R4: Mode code 2 rounds toward plus infinity (1.1 gives 2, -1.9 gives -1).
- R5: Mode code 3 rounds toward minus infinity (1.9 gives 1, -1.1 gives -2).
- R6: For a valid conversion, `inexact` is 1 exactly when the rounded integer differs from the operand's value. Zero, integral operands and subnormals are handled by the same rule.
- R7: A NaN or infinite operand gives `invalid` = 1, `inexact` = 0 and `result` = 0x7FFFFFFF, whatever the mode.
- R8: An operand whose rounded value is above 2^31-1 or below -2^31 gives `invalid` = 1, `inexact` = 0 and `result` = 0x7FFFFFFF.
- R9: A rounded value of exactly -2^31 is valid and gives 0x80000000. This includes -2^31 itself and operands that round onto it.
- R10: While `rst_n` is low, `outValid`, `result`, `inexact` and `invalid` are all 0.
- R11: In a cycle that follows a cycle with `inValid` low, `result`, `inexact` and `invalid` are unchanged from the cycle before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operand and mode are presented this cycle |
| operand | input | 64 | IEEE-754 binary64 operand |
| roundMode | input | 2 | 0 nearest-even, 1 toward zero, 2 toward +inf, 3 toward -inf |
| outValid | output | 1 | Result of the previous cycle's conversion is present |
| result | output | 32 | Signed integer result, or 0x7FFFFFFF when invalid |
| inexact | output | 1 | Rounding changed the value |
| invalid | output | 1 | NaN, infinity or out-of-range operand |

## Verification
The properties assume that `operand` and `roundMode` are fully defined (no X or Z bits) in every cycle where `inValid` is high. They also assume that reset is held for at least one clock edge before the first strobe. The stimulus drives both inputs from known values at every strobe and keeps them at zero while idle. Random operands have exponents spread around the ±2^31 boundary so that overflow, ties and exact values all occur. Directed cases cover NaN, both infinities, subnormals and the neighbours of ±2^31.

// File: rtl/d2i_pkg.sv
package d2i_pkg;

  typedef enum logic [1:0] {
    RM_NEAREST = 2'd0,
    RM_ZERO    = 2'd1,
    RM_UP      = 2'd2,
    RM_DOWN    = 2'd3
  } roundMode_e;

  typedef struct packed {
    logic load;
  } ctrlStrobe_t;

endpackage

// File: rtl/d2i_control.sv
module d2i_control
  import d2i_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inValid,
  output ctrlStrobe_t stb,
  output logic        outValid
);

  always_comb begin
    stb      = '0;
    stb.load = inValid;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) outValid <= 1'b0;
    else        outValid <= inValid;
  end

endmodule

// File: rtl/d2i_datapath.sv
module d2i_datapath
  import d2i_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int INT_W  = 32,
  localparam int OP_W  = 1 + EXP_W + FRAC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobe_t       stb,
  input  logic [OP_W-1:0]   operand,
  input  roundMode_e        mode,
  output logic [INT_W-1:0]  result,
  output logic              inexact,
  output logic              invalid
);

  localparam int MANT_W = FRAC_W + 1;
  localparam int XFR_W  = 2 * MANT_W;
  localparam int WIDE_W = MANT_W + XFR_W;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int LOW_E  = FRAC_W - XFR_W + 1;
  localparam logic [INT_W-1:0] INVALID_VAL = {1'b0, {(INT_W-1){1'b1}}};

  logic              signBit;
  logic [EXP_W-1:0]  expField;
  logic [FRAC_W-1:0] fracField;
  int                expUnb;
  int                shAmt;
  logic              isSpecial, tooBig, tiny;
  logic [WIDE_W-1:0] wide;
  logic [INT_W-1:0]  intPart;
  logic              hiRest, rndBit, stkBit, incBit;
  logic [INT_W:0]    mag;
  logic              rangeErr, badOp;
  logic [INT_W-1:0]  signedVal;

  assign signBit   = operand[OP_W-1];
  assign expField  = operand[OP_W-2 -: EXP_W];
  assign fracField = operand[FRAC_W-1:0];

  always_comb begin
    expUnb    = int'(expField) - BIAS;
    isSpecial = &expField;
    tooBig    = !isSpecial && (expUnb >= INT_W);
    tiny      = expUnb < LOW_E;
    shAmt     = (isSpecial || tooBig || tiny) ? 0 : (FRAC_W - expUnb);
    wide      = {1'b1, fracField, {XFR_W{1'b0}}} >> shAmt;

    if (tiny) begin
      intPart = '0;
      hiRest  = 1'b0;
      rndBit  = 1'b0;
      stkBit  = |operand[OP_W-2:0];
    end else begin
      intPart = wide[XFR_W +: INT_W];
      hiRest  = |wide[WIDE_W-1:XFR_W+INT_W];
      rndBit  = wide[XFR_W-1];
      stkBit  = |wide[XFR_W-2:0];
    end

    unique case (mode)
      RM_NEAREST: incBit = rndBit & (stkBit | intPart[0]);
      RM_ZERO:    incBit = 1'b0;
      RM_UP:      incBit = (rndBit | stkBit) & !signBit;
      RM_DOWN:    incBit = (rndBit | stkBit) & signBit;
      default:    incBit = 1'b0;
    endcase

    mag = {1'b0, intPart} + {{INT_W{1'b0}}, incBit};

    if (signBit)
      rangeErr = mag[INT_W] || (mag[INT_W-1] && (|mag[INT_W-2:0]));
    else
      rangeErr = mag[INT_W] || mag[INT_W-1];

    badOp     = isSpecial || tooBig || hiRest || rangeErr;
    signedVal = signBit ? (~mag[INT_W-1:0] + 1'b1) : mag[INT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result  <= '0;
      inexact <= 1'b0;
      invalid <= 1'b0;
    end else if (stb.load) begin
      result  <= badOp ? INVALID_VAL : signedVal;
      inexact <= !badOp && (rndBit || stkBit);
      invalid <= badOp;
    end
  end

endmodule

// File: rtl/d2i_convert.sv
module d2i_convert
  import d2i_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int INT_W  = 32,
  localparam int OP_W  = 1 + EXP_W + FRAC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inValid,
  input  logic [OP_W-1:0]  operand,
  input  logic [1:0]       roundMode,
  output logic             outValid,
  output logic [INT_W-1:0] result,
  output logic             inexact,
  output logic             invalid
);

  ctrlStrobe_t stb;

  d2i_control u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .stb      (stb),
    .outValid (outValid)
  );

  d2i_datapath #(
    .EXP_W  (EXP_W),
    .FRAC_W (FRAC_W),
    .INT_W  (INT_W)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .stb     (stb),
    .operand (operand),
    .mode    (roundMode_e'(roundMode)),
    .result  (result),
    .inexact (inexact),
    .invalid (invalid)
  );

endmodule

// File: rtl/d2i_checker.sv
module d2i_checker #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int INT_W  = 32,
  localparam int OP_W  = 1 + EXP_W + FRAC_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             inValid,
  input logic [OP_W-1:0]  operand,
  input logic [1:0]       roundMode,
  input logic             outValid,
  input logic [INT_W-1:0] result,
  input logic             inexact,
  input logic             invalid
);

  localparam int BIAS = (1 << (EXP_W - 1)) - 1;
  localparam logic [EXP_W-1:0] MININT_EXP = EXP_W'(BIAS + INT_W - 1);
  localparam logic [OP_W-1:0]  MININT_OP  = {1'b1, MININT_EXP, {FRAC_W{1'b0}}};
  localparam logic [INT_W-1:0] INVALID_VAL = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] MININT_VAL  = {1'b1, {(INT_W-1){1'b0}}};

  p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);

  p_valid_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid);

  p_invalid_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    invalid |-> (result == INVALID_VAL) && !inexact);

  p_special_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && (&operand[OP_W-2 -: EXP_W])) |=> invalid);

  p_zero_exact_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && (operand[OP_W-2:0] == '0)) |=> (result == '0) && !inexact && !invalid);

  p_minint_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && (operand == MININT_OP)) |=> (result == MININT_VAL) && !invalid && !inexact);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> $stable(result) && $stable(inexact) && $stable(invalid));

  p_mode_known_r2: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |-> !$isunknown(roundMode));

endmodule

bind d2i_convert d2i_checker #(
  .EXP_W  (EXP_W),
  .FRAC_W (FRAC_W),
  .INT_W  (INT_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .inValid   (inValid),
  .operand   (operand),
  .roundMode (roundMode),
  .outValid  (outValid),
  .result    (result),
  .inexact   (inexact),
  .invalid   (invalid)
);

// File: tb/d2i_convert_tb.sv
module d2i_convert_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic [63:0] operand = '0;
  logic [1:0]  roundMode = '0;
  logic        outValid;
  logic [31:0] result;
  logic        inexact;
  logic        invalid;

  int testCnt = 0;
  int failCnt = 0;
  int cycles  = 0;

  // expected outputs for the current cycle
  logic        expV = 1'b0;
  logic [31:0] expR = '0;
  logic        expX = 1'b0;
  logic        expI = 1'b0;
  string       expTag = "R10";

  always #10 clk = ~clk;

  d2i_convert dut_i (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .operand(operand),
    .roundMode(roundMode), .outValid(outValid), .result(result),
    .inexact(inexact), .invalid(invalid)
  );

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        failCnt++;
        $display("FAIL watchdog: run did not finish");
        finishRun();
      end
    end
  end

  function automatic string modeTag(input logic [1:0] m);
    case (m)
      2'd0: return "R2";
      2'd1: return "R3";
      2'd2: return "R4";
      default: return "R5";
    endcase
  endfunction

  // behavioural reference in real arithmetic
  task automatic refModel(input logic [63:0] op, input logic [1:0] m,
                          output logic [31:0] r, output logic x, output logic i);
    real v, lo, hi, rv;
    if (&op[62:52]) begin
      r = 32'h7FFFFFFF; x = 1'b0; i = 1'b1;
      return;
    end
    v  = $bitstoreal(op);
    lo = $floor(v);
    hi = $ceil(v);
    case (m)
      2'd0: begin
        if (hi - v < v - lo)      rv = hi;
        else if (hi - v > v - lo) rv = lo;
        else                      rv = ($floor(lo / 2.0) * 2.0 == lo) ? lo : hi;
      end
      2'd1: rv = (v < 0.0) ? hi : lo;
      2'd2: rv = hi;
      default: rv = lo;
    endcase
    if (rv > 2147483647.0 || rv < -2147483648.0) begin
      r = 32'h7FFFFFFF; x = 1'b0; i = 1'b1;
    end else begin
      r = 32'($rtoi(rv)); x = (rv != v); i = 1'b0;
    end
  endtask

  task automatic checkNow();
    testCnt++;
    if (outValid !== expV) begin
      failCnt++;
      $display("FAIL R1 outValid actual=%b expected=%b", outValid, expV);
    end
    testCnt++;
    if (result !== expR || inexact !== expX || invalid !== expI) begin
      failCnt++;
      $display("FAIL %s result/inexact/invalid actual=%h/%b/%b expected=%h/%b/%b",
               expTag, result, inexact, invalid, expR, expX, expI);
    end
  endtask

  // one clock: check what the DUT shows now, then present the next input
  task automatic step(input logic vld, input logic [63:0] op,
                      input logic [1:0] m, input string tag);
    logic [31:0] r;
    logic x, i;
    @(negedge clk);
    checkNow();
    inValid   = vld;
    operand   = vld ? op : '0;
    roundMode = vld ? m : '0;
    expV      = vld;
    if (vld) begin
      refModel(op, m, r, x, i);
      expR = r; expX = x; expI = i;
      expTag = tag;
    end else begin
      expTag = "R11";
    end
  endtask

  task automatic conv(input real val, input logic [1:0] m, input string tag);
    step(1'b1, $realtobits(val), m, tag);
  endtask

  initial begin
    real ties [8];
    ties = '{2.5, 3.5, -2.5, -3.5, 1.9, -1.9, 1.1, -1.1};
    // R10: reset state observed during reset
    repeat (3) begin
      @(negedge clk);
      checkNow();
    end
    @(negedge clk);
    rst_n = 1'b1;
    expTag = "R10";

    // R2..R5: each mode over the same small values
    for (int m = 0; m < 4; m++)
      for (int k = 0; k < 8; k++)
        conv(ties[k], 2'(m), modeTag(2'(m)));

    // R6: exact and nearly exact values
    conv(0.0, 2'd2, "R6");
    conv(-0.0, 2'd3, "R6");
    conv(7.0, 2'd0, "R6");
    conv(-123456.0, 2'd1, "R6");
    step(1'b1, 64'h0000_0000_0000_0001, 2'd2, "R6");
    step(1'b1, 64'h8000_0000_0000_0001, 2'd3, "R6");
    step(1'b1, 64'h0000_0000_0000_0001, 2'd0, "R6");
    conv(0.5, 2'd0, "R6");
    conv(0.5000001, 2'd0, "R6");

    // R7: specials, in every mode
    for (int m = 0; m < 4; m++) begin
      step(1'b1, 64'h7FF8_0000_0000_0000, 2'(m), "R7");
      step(1'b1, 64'h7FF0_0000_0000_0000, 2'(m), "R7");
      step(1'b1, 64'hFFF0_0000_0000_0000, 2'(m), "R7");
    end

    // R8 / R9: around the signed range limits
    conv(2147483647.0, 2'd0, "R8");
    conv(2147483647.5, 2'd0, "R8");
    conv(2147483647.5, 2'd1, "R8");
    conv(2147483648.0, 2'd1, "R8");
    conv(3.0e9, 2'd3, "R8");
    conv(1.0e300, 2'd0, "R8");
    conv(-2147483649.0, 2'd2, "R8");
    conv(-2147483648.5, 2'd3, "R8");
    conv(-2147483648.0, 2'd0, "R9");
    conv(-2147483648.5, 2'd1, "R9");
    conv(-2147483648.5, 2'd0, "R9");
    conv(-2147483648.7, 2'd2, "R9");

    // R1 / R11: gaps between strobes
    conv(5.5, 2'd0, "R1");
    step(1'b0, '0, 2'd0, "R11");
    step(1'b0, '0, 2'd0, "R11");
    conv(-5.5, 2'd2, "R1");

    // mixed random traffic with exponents around the range limit
    for (int n = 0; n < 400; n++) begin
      logic [63:0] op;
      logic [1:0]  m;
      op[63]    = 1'($urandom % 2);
      op[62:52] = 11'(1018 + ($urandom % 40));
      op[51:0]  = {20'($urandom), 32'($urandom)};
      m         = 2'($urandom % 4);
      if ($urandom % 4 == 0) step(1'b0, '0, 2'd0, "R11");
      step(1'b1, op, m, modeTag(m));
    end

    step(1'b0, '0, 2'd0, "R11");
    step(1'b0, '0, 2'd0, "R11");
    @(negedge clk);
    checkNow();
    finishRun();
  end

endmodule